// File: doc/BRIEF.md
# Double-Precision to 64-bit Integer Converter

This block takes a 64-bit IEEE 754 double-precision operand and converts it to a signed 64-bit two's-complement integer. The rounding direction is chosen per conversion by a 2-bit mode input. Each conversion also reports two exception flags: invalid and inexact. The block is a one-stage pipeline. An operand presented with `in_valid` high produces its result, its flags and `out_valid` on the next rising clock edge. A new operand can be accepted every cycle.

The decode step places the operand in one of five classes: `CLS_ZERO`, `CLS_SUB` (subnormal), `CLS_NORM`, `CLS_INF` and `CLS_NAN`. The class selects the result path.
- NaN returns the indefinite value.
- Infinity saturates according to its sign.
- Zero returns 0.
- Subnormal and normal operands go through a single alignment shifter. The shifter produces the integer magnitude, a round bit and a sticky bit. A rounding stage then applies the selected mode and checks the rounded magnitude for overflow.

The sign is applied last.

There is no state machine. The pipeline transitions are the capture of the operand class on a cycle with `in_valid` high (valid to done) and the dropping of `out_valid` after a cycle with `in_valid` low (done to idle). While `in_valid` is low the result and flag registers hold their previous values.

Top module: `dti_conv`

## Requirements
- R1: A NaN operand (exponent field all ones, fraction nonzero, either sign) returns 0x7FFF_FFFF_FFFF_FFFF with invalid set and inexact clear.
- R2: An infinite operand (exponent field all ones, fraction zero) returns 0x7FFF_FFFF_FFFF_FFFF for +inf and 0x8000_0000_0000_0000 for -inf, with invalid set and inexact clear.
- R3: A zero operand of either sign returns 0 with both flags clear.
- R4: An unbiased exponent (field minus 1023) of 63 or more saturates by sign with invalid set. The one exception is exponent 63, negative sign and zero fraction, which returns 0x8000_0000_0000_0000 with no flag.
- R5: An unbiased exponent from 52 to 62 returns the significand (hidden bit included) shifted left by exponent minus 52, negated for a negative sign, with both flags clear.
- R6: Mode 2'b00 rounds to nearest with ties to even. The magnitude is incremented when the discarded part exceeds one half, or equals one half and the integer LSB is 1.
- R7: Mode 2'b01 rounds toward zero. The magnitude is never incremented.
- R8: Mode 2'b10 rounds toward +inf: the magnitude is incremented when any discarded bit is nonzero and the sign is positive. Mode 2'b11 rounds toward -inf: the magnitude is incremented when any discarded bit is nonzero and the sign is negative.
- R9: Inexact is set exactly when the conversion is not invalid and nonzero bits were discarded. Invalid and inexact are never set together. A subnormal operand (exponent field 0, unbiased exponent -1022, no hidden bit) always has a zero integer part with discarded bits, so it returns 0, +1 or -1 according to the mode, with inexact set.
- R10: `out_valid` equals `in_valid` delayed by one clock. Result and flags update on the edge that samples `in_valid` high. After reset, `out_valid`, the result and both flags are 0.
- R11: A valid result for a negative operand is the two's complement of the rounded magnitude. If the rounded magnitude reaches 2^63, the block saturates by sign and sets invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and mode are valid this cycle |
| op_bits | input | 64 | Double-precision operand |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result and flags are from the previous valid operand |
| int_res | output | 64 | Signed two's-complement integer result |
| flag_invalid | output | 1 | Invalid-operation flag for this conversion |
| flag_inexact | output | 1 | Inexact flag for this conversion |

## Verification
The assertions assume that `op_bits` and `rnd_mode` carry known values in every cycle where `in_valid` is high. They also assume that the only way to retire a result is through the one-cycle relation between `in_valid` and `out_valid`.

The stimulus changes inputs only on the falling clock edge. It drives all four mode codes with defined values and lowers `in_valid` only at the end of the run, where the idle transition is checked.

The sweep walks biased exponents from 1000 to 1090 so that it covers every alignment region: deep fraction, the half point, exact shifts and saturation. Each exponent is combined with fraction patterns that give ties, values above and below one half, and odd and even LSBs, under both signs.

// File: rtl/dti_pkg.sv
package dti_pkg;
    localparam int FP_W    = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int INT_W   = 64;
    localparam int UEXP_W  = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int WIDE_W  = 2 * INT_W;
    localparam int SH_W    = $clog2(WIDE_W);

    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] INDEF   = INT_MAX;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_NAN  = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/dti_classify.sv
module dti_classify
    import dti_pkg::*;
(
    input  logic [FP_W-1:0]          op,
    output op_class_e                cls,
    output logic                     sign,
    output logic signed [UEXP_W-1:0] exp_unb,
    output logic [SIG_W-1:0]         sig
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac;

    assign sign  = op[FP_W-1];
    assign exp_f = op[FP_W-2 -: EXP_W];
    assign frac  = op[FRAC_W-1:0];

    always_comb begin
        if (exp_f == '1)
            cls = (frac != '0) ? CLS_NAN : CLS_INF;
        else if (exp_f == '0)
            cls = (frac != '0) ? CLS_SUB : CLS_ZERO;
        else
            cls = CLS_NORM;
    end

    // subnormals share the minimum normal exponent and lack the hidden bit
    assign exp_unb = (exp_f == '0) ? UEXP_W'(1 - BIAS)
                                   : $signed({2'b00, exp_f}) - UEXP_W'(BIAS);
    assign sig     = {exp_f != '0, frac};
endmodule

// File: rtl/dti_align.sv
module dti_align
    import dti_pkg::*;
(
    input  logic signed [UEXP_W-1:0] exp_unb,
    input  logic [SIG_W-1:0]         sig,
    output logic [INT_W-1:0]         int_mag,
    output logic                     rnd_bit,
    output logic                     stk_bit
);
    // fixed point: integer part in the top half, fraction in the bottom half
    localparam int PT_OFS = INT_W - FRAC_W;

    logic [SH_W-1:0]   sh;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        sh   = '0;
        wide = '0;
        if (exp_unb < -1) begin
            int_mag = '0;
            rnd_bit = 1'b0;
            stk_bit = |sig;
        end else begin
            sh      = SH_W'(exp_unb + UEXP_W'(PT_OFS));
            wide    = {{(WIDE_W-SIG_W){1'b0}}, sig} << sh;
            int_mag = wide[WIDE_W-1:INT_W];
            rnd_bit = wide[INT_W-1];
            stk_bit = |wide[INT_W-2:0];
        end
    end
endmodule

// File: rtl/dti_round.sv
module dti_round
    import dti_pkg::*;
(
    input  rnd_mode_e        mode,
    input  logic             sign,
    input  logic [INT_W-1:0] mag_in,
    input  logic             rnd_bit,
    input  logic             stk_bit,
    output logic [INT_W-1:0] mag_out,
    output logic             mag_ovf,
    output logic             lost
);
    logic inc;

    assign lost = rnd_bit | stk_bit;

    always_comb begin
        unique case (mode)
            RM_NEAR: inc = rnd_bit & (stk_bit | mag_in[0]);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = lost & ~sign;
            RM_DOWN: inc = lost & sign;
        endcase
    end

    assign mag_out = mag_in + INT_W'(inc);
    assign mag_ovf = mag_out[INT_W-1];
endmodule

// File: rtl/dti_conv.sv
module dti_conv
    import dti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FP_W-1:0]   op_bits,
    input  logic [1:0]        rnd_mode,
    output logic              out_valid,
    output logic [INT_W-1:0]  int_res,
    output logic              flag_invalid,
    output logic              flag_inexact
);
    op_class_e                cls;
    logic                     sign;
    logic signed [UEXP_W-1:0] exp_unb;
    logic [SIG_W-1:0]         sig;
    logic [INT_W-1:0]         mag_a, mag_r;
    logic                     rnd_b, stk_b, ovf, lost;

    logic [INT_W-1:0] res_d;
    logic             inv_d, inx_d;

    dti_classify u_cls (
        .op(op_bits), .cls(cls), .sign(sign), .exp_unb(exp_unb), .sig(sig)
    );

    dti_align u_aln (
        .exp_unb(exp_unb), .sig(sig),
        .int_mag(mag_a), .rnd_bit(rnd_b), .stk_bit(stk_b)
    );

    dti_round u_rnd (
        .mode(rnd_mode_e'(rnd_mode)), .sign(sign), .mag_in(mag_a),
        .rnd_bit(rnd_b), .stk_bit(stk_b),
        .mag_out(mag_r), .mag_ovf(ovf), .lost(lost)
    );

    // output selection per operand class
    always_comb begin
        res_d = '0;
        inv_d = 1'b0;
        inx_d = 1'b0;
        unique case (cls)
            CLS_NAN: begin
                res_d = INDEF;
                inv_d = 1'b1;
            end
            CLS_INF: begin
                res_d = sign ? INT_MIN : INT_MAX;
                inv_d = 1'b1;
            end
            CLS_ZERO: res_d = '0;
            CLS_SUB, CLS_NORM: begin
                if (exp_unb >= UEXP_W'(INT_W - 1)) begin
                    if (exp_unb == UEXP_W'(INT_W - 1) && sign &&
                        sig[FRAC_W-1:0] == '0) begin
                        res_d = INT_MIN;
                    end else begin
                        res_d = sign ? INT_MIN : INT_MAX;
                        inv_d = 1'b1;
                    end
                end else if (ovf) begin
                    res_d = sign ? INT_MIN : INT_MAX;
                    inv_d = 1'b1;
                end else begin
                    res_d = sign ? (~mag_r + INT_W'(1)) : mag_r;
                    inx_d = lost;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            int_res      <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                int_res      <= res_d;
                flag_invalid <= inv_d;
                flag_inexact <= inx_d;
            end
        end
    end

    AST_NAN_INDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_bits[62:52] == '1 && op_bits[51:0] != '0)
        |=> (int_res == INDEF && flag_invalid && !flag_inexact)); // R1

    AST_INF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_bits[62:52] == '1 && op_bits[51:0] == '0)
        |=> (flag_invalid && int_res == ($past(op_bits[63]) ? INT_MIN : INT_MAX))); // R2

    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_bits[62:0] == '0)
        |=> (int_res == '0 && !flag_invalid && !flag_inexact)); // R3

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(flag_invalid && flag_inexact)); // R9

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(int_res))); // R10
endmodule

// File: tb/sim_dti_conv.sv
module sim_dti_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_bits = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [63:0] int_res;
    logic        flag_invalid, flag_inexact;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dti_conv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_bits(op_bits),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .int_res(int_res),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;

    // arithmetic reference: integer quotient and remainder against one half
    task automatic ref_conv(input logic [63:0] op, input logic [1:0] m,
                            output logic [63:0] res, output logic inv,
                            output logic inx);
        logic        s;
        int          ef, ue, sh;
        logic [51:0] f;
        logic [63:0] sg, q, r, half;
        int          cmp;  // 0 exact, 1 below half, 2 half, 3 above half
        logic        up;
        s  = op[63];
        ef = int'(op[62:52]);
        f  = op[51:0];
        res = '0; inv = 1'b0; inx = 1'b0;
        if (ef == 2047) begin
            inv = 1'b1;
            res = (f != 0) ? MAXV : (s ? MINV : MAXV);
            return;
        end
        if (ef == 0 && f == 0) return;
        ue = (ef == 0) ? -1022 : ef - 1023;
        sg = (ef == 0) ? {12'd0, f} : {11'd0, 1'b1, f};
        if (ue >= 63) begin
            if (ue == 63 && s && f == 0) res = MINV;
            else begin inv = 1'b1; res = s ? MINV : MAXV; end
            return;
        end
        cmp = 0; q = '0;
        if (ue >= 52) q = sg << (ue - 52);
        else if (ue >= 0) begin
            sh   = 52 - ue;
            q    = sg >> sh;
            r    = sg - (q << sh);
            half = 64'd1 << (sh - 1);
            cmp  = (r == 0) ? 0 : (r < half) ? 1 : (r == half) ? 2 : 3;
        end else if (ue == -1) cmp = (f == 0) ? 2 : 3;
        else cmp = 1;
        case (m)
            2'b00:   up = (cmp == 3) || (cmp == 2 && q[0]);
            2'b01:   up = 1'b0;
            2'b10:   up = (cmp != 0) && !s;
            default: up = (cmp != 0) && s;
        endcase
        q = q + 64'(up);
        if (q[63]) begin inv = 1'b1; res = s ? MINV : MAXV; return; end
        inx = (cmp != 0);
        res = s ? (64'd0 - q) : q;
    endtask

    task automatic check(input string tag, input logic [63:0] got,
                         input logic [63:0] exp, input logic gi,
                         input logic ei, input logic gx, input logic ex,
                         input logic gv, input logic ev);
        n_chk++;
        if (got !== exp || gi !== ei || gx !== ex || gv !== ev) begin
            n_bad++;
            $display("FAIL %s: res=%h inv=%b inx=%b vld=%b expected res=%h inv=%b inx=%b vld=%b",
                     tag, got, gi, gx, gv, exp, ei, ex, ev);
        end
    endtask

    task automatic convert(input logic [63:0] op, input logic [1:0] m,
                           input string tag);
        logic [63:0] er;
        logic ei, ex;
        ref_conv(op, m, er, ei, ex);
        @(negedge clk);
        op_bits  = op;
        rnd_mode = m;
        in_valid = 1'b1;
        @(negedge clk);
        check(tag, int_res, er, flag_invalid, ei, flag_inexact, ex, out_valid, 1'b1);
    endtask

    function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
        return {s, 11'(e), f};
    endfunction

    initial begin
        logic [51:0] pats [7];
        pats[0] = 52'h0;
        pats[1] = 52'h1;
        pats[2] = 52'h8000000000000;
        pats[3] = 52'hFFFFFFFFFFFFF;
        pats[4] = 52'h5555555555555;
        pats[5] = 52'h0000000080000;
        pats[6] = 52'h8000000000001;

        repeat (3) @(negedge clk);
        check("R10 reset", int_res, 64'd0, flag_invalid, 1'b0, flag_inexact, 1'b0, out_valid, 1'b0);
        rst_n = 1'b1;

        // R1 NaN, quiet and signalling, both signs
        convert(mk(1'b0, 2047, 52'h8000000000000), 2'b00, "R1 qnan");
        convert(mk(1'b1, 2047, 52'h0000000000001), 2'b11, "R1 snan");
        // R2 infinities
        convert(mk(1'b0, 2047, 52'h0), 2'b01, "R2 +inf");
        convert(mk(1'b1, 2047, 52'h0), 2'b10, "R2 -inf");
        // R3 zeros
        convert(mk(1'b0, 0, 52'h0), 2'b10, "R3 +0");
        convert(mk(1'b1, 0, 52'h0), 2'b11, "R3 -0");
        // R4 boundary at 2^63
        convert(mk(1'b1, 1086, 52'h0), 2'b00, "R4 exact min");
        convert(mk(1'b1, 1086, 52'h1), 2'b00, "R4 below min");
        convert(mk(1'b0, 1086, 52'h0), 2'b00, "R4 +2^63");
        // R9 subnormals in every mode
        for (int m = 0; m < 4; m++) begin
            convert(mk(1'b0, 0, 52'h0000000000001), 2'(m), "R9 +sub");
            convert(mk(1'b1, 0, 52'hFFFFFFFFFFFFF), 2'(m), "R9 -sub");
        end
        // R11 negative two's complement: -2.5 nearest -> -2, -3.5 -> -4
        convert(mk(1'b1, 1024, 52'h4000000000000), 2'b00, "R11 -2.5");
        convert(mk(1'b1, 1024, 52'hC000000000000), 2'b00, "R11 -3.5");

        // sweep across the alignment regions
        for (int e = 1000; e <= 1090; e++)
            for (int p = 0; p < 7; p++)
                for (int s = 0; s < 2; s++)
                    for (int m = 0; m < 4; m++) begin
                        string tag;
                        if (e - 1023 >= 63)      tag = "R4 sweep";
                        else if (e - 1023 >= 52) tag = "R5 sweep";
                        else if (m == 0)         tag = "R6 sweep";
                        else if (m == 1)         tag = "R7 sweep";
                        else                     tag = "R8 sweep";
                        convert(mk(1'(s), e, pats[p]), 2'(m), tag);
                    end

        // R10 idle: out_valid drops, result holds
        begin
            logic [63:0] held;
            held = int_res;
            @(negedge clk);
            in_valid = 1'b0;
            op_bits  = 64'h4000_0000_0000_0000;
            @(negedge clk);
            check("R10 idle", int_res, held, flag_invalid, flag_invalid,
                  flag_inexact, flag_inexact, out_valid, 1'b0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule